// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block brings one power-gated domain up or down by driving its control lines one step at a time in a fixed order. It drives the main and auxiliary power switch enables, a clock gate, an isolation enable, an active-low domain reset, and a set of retention-flop controls: a retention clock gate, a save pulse, an active-low restore pulse and a separate clock gate for storage-style retention. It also keeps a saved-state flag. The block decides that the domain is powered only when both status inputs read high. It bounds every wait with a cycle limit.

A retention kind input selects the save/restore variant. A modem mode replaces the full switch sequence with a short reset-plus-main-switch sequence. The memory power-up/down step and the fabric protection step are done by companion blocks. The sequencer starts each one with a one-cycle start pulse and waits for a done or fail reply. `opUp` tells the companions the direction of the current operation. Each operation ends with a one-cycle `done`. `fault` is high in that same cycle if the operation was abandoned.

Top module: `pwrseq_top`

## Requirements
- R1: With modem mode off, a power-on request acts in this order: main switch on, then auxiliary switch on, then a wait until both status inputs are high, then clock gate released, then isolation released, then domain reset released (`domRstN` high). Only after all of this does the memory handshake start, followed by the fabric handshake.
- R2: The domain counts as powered only when `staMain` and `staAux` are both high. If that has not happened after ACK_LIMIT cycles, the operation ends with `done` and `fault` high, and no later step is taken.
- R3: For retention kind 2 (PHY-style), `retClkOff` is set before the clock gate is released. Reset is released at least PHY_ON_GAP cycles after isolation is released. For the other kinds, reset follows isolation release with no such gap.
- R4: For kind 1 (generic), power-on with `savedFlag` set runs this restore after reset release: clear the flag, set `retClkOff`, drive `retRestoreN` low then high, clear `retClkOff`.
- R5: Kind 2 restores with the same steps as kind 1, minus the setting of `retClkOff`. Kind 3 (storage) always restores, whatever the flag. It brackets the restore pulse with `storClkOff` set then cleared, and it leaves the flag untouched.
- R6: With kind 0, or with kind 1 or 2 and `savedFlag` clear, power-on ends its switch sequence at reset release, with no restore activity.
- R7: Power-off first runs the fabric handshake, then the memory handshake, then the save. For kinds 1 and 2 the save is: set `retClkOff`, raise `retSave`, lower `retSave`, clear `retClkOff`, set `savedFlag`. Kind 3 does the same with `storClkOff` and does not set the flag. Kind 0 has no save.
- R8: After the save, power-off asserts isolation, then sets the clock gate, then asserts reset, then drops the auxiliary switch, then drops the main switch. It then waits until the domain no longer reads as powered. For kind 2, at least PHY_OFF_GAP cycles pass between the isolation assert and the clock gate.
- R9: In modem mode, power-on releases reset (skipped when `skipRst` is high) and then turns on only the main switch. Power-off drops the main switch and then asserts reset (again skipped with `skipRst`). The retention kind has no effect in this mode.
- R10: `opUp` is high during a power-on and low during a power-off. A successful operation ends with `done` high and `fault` low.
- R11: A fail reply from a companion, or no reply within HS_LIMIT cycles, ends the operation with `fault` high, and no later step is taken.
- R12: After reset the switches are off, the clock gate and isolation are set, `domRstN` and all retention controls are inactive (`retRestoreN` high), `savedFlag` is clear, and `busy` is low.
- R13: A request that arrives while an operation is running is ignored. No control output changes after that operation's `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of the sequencer |
| onReq | input | 1 | Start power-on (taken when idle) |
| offReq | input | 1 | Start power-off (taken when idle) |
| retKind | input | 2 | Retention kind: 0 none, 1 generic, 2 PHY-style, 3 storage |
| modemMode | input | 1 | Select the short modem sequence |
| skipRst | input | 1 | In modem mode, leave the reset line alone |
| staMain | input | 1 | First power status |
| staAux | input | 1 | Second power status |
| memDone | input | 1 | Memory step finished |
| memFail | input | 1 | Memory step failed |
| fabDone | input | 1 | Fabric protection step finished |
| fabFail | input | 1 | Fabric protection step failed |
| swMain | output | 1 | Main power switch enable |
| swAux | output | 1 | Auxiliary power switch enable |
| clkGate | output | 1 | Domain clock disable |
| isoEn | output | 1 | Domain isolation enable |
| domRstN | output | 1 | Active-low domain reset |
| retClkOff | output | 1 | Retention clock disable |
| retSave | output | 1 | Retention save pulse |
| retRestoreN | output | 1 | Active-low retention restore pulse |
| storClkOff | output | 1 | Storage-kind retention clock disable |
| savedFlag | output | 1 | Retention state has been saved |
| memStart | output | 1 | One-cycle start for the memory companion |
| fabStart | output | 1 | One-cycle start for the fabric companion |
| opUp | output | 1 | Direction of the current operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| fault | output | 1 | Operation abandoned (valid with done) |

## Verification
The bench records every control-line change as an ordered event log with cycle stamps. It compares each log against a sequence built from the requirements. It sweeps all four retention kinds through two on/off cycles, so each kind powers on once with the saved flag clear and once with it set. This separates the flag-gated restore from the storage kind's unconditional restore. Modem mode is run with and without the reset skip. The cycle stamps tell the PHY-style isolation-to-reset gap apart from the immediate release of the other kinds. Stuck status and failing companions show that the sequence stops where the fault arises.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;

  typedef enum logic [1:0] {
    RET_NONE    = 2'd0,
    RET_GENERIC = 2'd1,
    RET_PHY     = 2'd2,
    RET_STORAGE = 2'd3
  } retKind_e;

  // Bit positions of the control register bank
  localparam int NUM_CTL  = 10;
  localparam int IDX_MAIN = 0;
  localparam int IDX_AUX  = 1;
  localparam int IDX_GATE = 2;
  localparam int IDX_ISO  = 3;
  localparam int IDX_RST  = 4;
  localparam int IDX_RCLK = 5;
  localparam int IDX_SAVE = 6;
  localparam int IDX_REST = 7;
  localparam int IDX_SCLK = 8;
  localparam int IDX_FLAG = 9;

  // Domain powered down: clock gated, isolated, reset held, restore idle
  localparam logic [NUM_CTL-1:0] CTL_RST =
    NUM_CTL'((1 << IDX_GATE) | (1 << IDX_ISO) | (1 << IDX_REST));

  typedef struct packed {
    logic mainOn;
    logic mainOff;
    logic auxOn;
    logic auxOff;
    logic gateSet;
    logic gateClr;
    logic isoSet;
    logic isoClr;
    logic rstRelease;
    logic rstApply;
    logic rclkSet;
    logic rclkClr;
    logic saveHi;
    logic saveLo;
    logic restLo;
    logic restHi;
    logic flagSet;
    logic flagClr;
    logic memGo;
    logic fabGo;
  } strobe_t;

endpackage

// File: rtl/pwrseq_ctrl.sv
`timescale 1ns/1ps
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int ACK_LIMIT   = 1000,
  parameter int HS_LIMIT    = 1000,
  parameter int PHY_ON_GAP  = 250,
  parameter int PHY_OFF_GAP = 50
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     onReq,
  input  logic     offReq,
  input  retKind_e kind,
  input  logic     modemMode,
  input  logic     skipRst,
  input  logic     staMain,
  input  logic     staAux,
  input  logic     savedFlag,
  input  logic     memDone,
  input  logic     memFail,
  input  logic     fabDone,
  input  logic     fabFail,
  output strobe_t  strb,
  output logic     busy,
  output logic     done,
  output logic     fault,
  output logic     opUp
);

  localparam int MAX_AB = (ACK_LIMIT > HS_LIMIT) ? ACK_LIMIT : HS_LIMIT;
  localparam int MAX_GP = (PHY_ON_GAP > PHY_OFF_GAP) ? PHY_ON_GAP : PHY_OFF_GAP;
  localparam int MAX_L  = (MAX_AB > MAX_GP) ? MAX_AB : MAX_GP;
  localparam int CNT_W  = $clog2(MAX_L + 1);

  typedef enum logic [5:0] {
    S_IDLE, S_ON_MAIN, S_ON_AUX, S_ON_ACK, S_ON_RCLK, S_ON_GATE, S_ON_ISO,
    S_ON_GAP, S_ON_RST, S_RS_FLAG, S_RS_RCLK, S_RS_LO, S_RS_HI, S_RS_END,
    S_ON_MEM, S_ON_MEMW, S_ON_FAB, S_ON_FABW, S_MD_RST, S_MD_MAIN,
    S_OF_FAB, S_OF_FABW, S_OF_MEM, S_OF_MEMW, S_SV_RCLK, S_SV_HI, S_SV_LO,
    S_SV_END, S_SV_FLAG, S_OF_ISO, S_OF_GAP, S_OF_GATE, S_OF_RST, S_OF_AUX,
    S_OF_MAIN, S_MD_OFMAIN, S_MD_OFRST, S_OF_ACK, S_FIN, S_FAIL
  } state_e;

  state_e            state, stateNx;
  logic [CNT_W-1:0]  cnt;
  logic              opUpQ;
  logic              isOn;
  logic              doRestore;
  logic              ackOver, hsOver, onGapEnd, offGapEnd;

  assign isOn      = staMain & staAux;
  assign doRestore = (kind == RET_STORAGE) ||
                     (((kind == RET_GENERIC) || (kind == RET_PHY)) && savedFlag);
  assign ackOver   = (cnt == CNT_W'(ACK_LIMIT - 1));
  assign hsOver    = (cnt == CNT_W'(HS_LIMIT - 1));
  assign onGapEnd  = (cnt == CNT_W'(PHY_ON_GAP - 1));
  assign offGapEnd = (cnt == CNT_W'(PHY_OFF_GAP - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      opUpQ <= 1'b0;
    end else begin
      state <= stateNx;
      cnt   <= ((stateNx != state) || (state == S_IDLE)) ? '0 : cnt + 1'b1;
      if (state == S_IDLE && onReq)       opUpQ <= 1'b1;
      else if (state == S_IDLE && offReq) opUpQ <= 1'b0;
    end
  end

  always_comb begin
    stateNx = state;
    strb    = '0;
    unique case (state)
      S_IDLE: begin
        if (onReq)       stateNx = modemMode ? S_MD_RST : S_ON_MAIN;
        else if (offReq) stateNx = S_OF_FAB;
      end
      // ---- power-on, full sequence
      S_ON_MAIN: begin strb.mainOn = 1'b1; stateNx = S_ON_AUX; end
      S_ON_AUX:  begin strb.auxOn  = 1'b1; stateNx = S_ON_ACK; end
      S_ON_ACK: begin
        if (isOn)         stateNx = modemMode ? S_ON_MEM :
                                    (kind == RET_PHY) ? S_ON_RCLK : S_ON_GATE;
        else if (ackOver) stateNx = S_FAIL;
      end
      S_ON_RCLK: begin strb.rclkSet = 1'b1; stateNx = S_ON_GATE; end
      S_ON_GATE: begin strb.gateClr = 1'b1; stateNx = S_ON_ISO; end
      S_ON_ISO: begin
        strb.isoClr = 1'b1;
        stateNx     = (kind == RET_PHY) ? S_ON_GAP : S_ON_RST;
      end
      S_ON_GAP: if (onGapEnd) stateNx = S_ON_RST;
      S_ON_RST: begin
        strb.rstRelease = 1'b1;
        if (!doRestore)               stateNx = S_ON_MEM;
        else if (kind == RET_STORAGE) stateNx = S_RS_RCLK;
        else                          stateNx = S_RS_FLAG;
      end
      // ---- restore
      S_RS_FLAG: begin
        strb.flagClr = 1'b1;
        stateNx      = (kind == RET_GENERIC) ? S_RS_RCLK : S_RS_LO;
      end
      S_RS_RCLK: begin strb.rclkSet = 1'b1; stateNx = S_RS_LO;  end
      S_RS_LO:   begin strb.restLo  = 1'b1; stateNx = S_RS_HI;  end
      S_RS_HI:   begin strb.restHi  = 1'b1; stateNx = S_RS_END; end
      S_RS_END:  begin strb.rclkClr = 1'b1; stateNx = S_ON_MEM; end
      // ---- power-on, companions
      S_ON_MEM: begin strb.memGo = 1'b1; stateNx = S_ON_MEMW; end
      S_ON_MEMW: begin
        if (memFail || hsOver) stateNx = S_FAIL;
        else if (memDone)      stateNx = S_ON_FAB;
      end
      S_ON_FAB: begin strb.fabGo = 1'b1; stateNx = S_ON_FABW; end
      S_ON_FABW: begin
        if (fabFail || hsOver) stateNx = S_FAIL;
        else if (fabDone)      stateNx = S_FIN;
      end
      // ---- modem power-on
      S_MD_RST: begin
        strb.rstRelease = !skipRst;
        stateNx         = S_MD_MAIN;
      end
      S_MD_MAIN: begin strb.mainOn = 1'b1; stateNx = S_ON_ACK; end
      // ---- power-off, companions
      S_OF_FAB: begin strb.fabGo = 1'b1; stateNx = S_OF_FABW; end
      S_OF_FABW: begin
        if (fabFail || hsOver) stateNx = S_FAIL;
        else if (fabDone)      stateNx = S_OF_MEM;
      end
      S_OF_MEM: begin strb.memGo = 1'b1; stateNx = S_OF_MEMW; end
      S_OF_MEMW: begin
        if (memFail || hsOver) stateNx = S_FAIL;
        else if (memDone)      stateNx = modemMode ? S_MD_OFMAIN :
                                         (kind == RET_NONE) ? S_OF_ISO : S_SV_RCLK;
      end
      // ---- save
      S_SV_RCLK: begin strb.rclkSet = 1'b1; stateNx = S_SV_HI;  end
      S_SV_HI:   begin strb.saveHi  = 1'b1; stateNx = S_SV_LO;  end
      S_SV_LO:   begin strb.saveLo  = 1'b1; stateNx = S_SV_END; end
      S_SV_END: begin
        strb.rclkClr = 1'b1;
        stateNx      = (kind == RET_STORAGE) ? S_OF_ISO : S_SV_FLAG;
      end
      S_SV_FLAG: begin strb.flagSet = 1'b1; stateNx = S_OF_ISO; end
      // ---- power-off, full sequence
      S_OF_ISO: begin
        strb.isoSet = 1'b1;
        stateNx     = (kind == RET_PHY) ? S_OF_GAP : S_OF_GATE;
      end
      S_OF_GAP:  if (offGapEnd) stateNx = S_OF_GATE;
      S_OF_GATE: begin strb.gateSet  = 1'b1; stateNx = S_OF_RST;  end
      S_OF_RST:  begin strb.rstApply = 1'b1; stateNx = S_OF_AUX;  end
      S_OF_AUX:  begin strb.auxOff   = 1'b1; stateNx = S_OF_MAIN; end
      S_OF_MAIN: begin strb.mainOff  = 1'b1; stateNx = S_OF_ACK;  end
      // ---- modem power-off
      S_MD_OFMAIN: begin strb.mainOff = 1'b1; stateNx = S_MD_OFRST; end
      S_MD_OFRST: begin
        strb.rstApply = !skipRst;
        stateNx       = S_OF_ACK;
      end
      S_OF_ACK: begin
        if (!isOn)        stateNx = S_FIN;
        else if (ackOver) stateNx = S_FAIL;
      end
      S_FIN:   stateNx = S_IDLE;
      S_FAIL:  stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_FIN) || (state == S_FAIL);
  assign fault = (state == S_FAIL);
  assign opUp  = opUpQ;

  // R11: completion strobe lasts exactly one cycle
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: the acknowledge wait never outlives its limit
  assert_ack_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ON_ACK || state == S_OF_ACK) |-> (cnt < CNT_W'(ACK_LIMIT)));

  // R13: direction is frozen while an operation runs
  assert_dir_stable_R13: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(opUpQ));

endmodule

// File: rtl/pwrseq_dp.sv
`timescale 1ns/1ps
module pwrseq_dp
  import pwrseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  retKind_e           kind,
  output logic [NUM_CTL-1:0] ctl,
  output logic               memStart,
  output logic               fabStart
);

  logic [NUM_CTL-1:0] setV, clrV;
  logic               storSel;

  assign storSel = (kind == RET_STORAGE);

  always_comb begin
    setV = '0;
    clrV = '0;
    setV[IDX_MAIN] = strb.mainOn;     clrV[IDX_MAIN] = strb.mainOff;
    setV[IDX_AUX]  = strb.auxOn;      clrV[IDX_AUX]  = strb.auxOff;
    setV[IDX_GATE] = strb.gateSet;    clrV[IDX_GATE] = strb.gateClr;
    setV[IDX_ISO]  = strb.isoSet;     clrV[IDX_ISO]  = strb.isoClr;
    setV[IDX_RST]  = strb.rstRelease; clrV[IDX_RST]  = strb.rstApply;
    setV[IDX_SAVE] = strb.saveHi;     clrV[IDX_SAVE] = strb.saveLo;
    setV[IDX_REST] = strb.restHi;     clrV[IDX_REST] = strb.restLo;
    setV[IDX_FLAG] = strb.flagSet;    clrV[IDX_FLAG] = strb.flagClr;
    // retention clock strobes steer to the storage gate for that kind
    setV[IDX_RCLK] = strb.rclkSet & !storSel;
    clrV[IDX_RCLK] = strb.rclkClr & !storSel;
    setV[IDX_SCLK] = strb.rclkSet & storSel;
    clrV[IDX_SCLK] = strb.rclkClr & storSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl      <= CTL_RST;
      memStart <= 1'b0;
      fabStart <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CTL; i++) begin
        if (setV[i])      ctl[i] <= 1'b1;
        else if (clrV[i]) ctl[i] <= 1'b0;
      end
      memStart <= strb.memGo;
      fabStart <= strb.fabGo;
    end
  end

  // R8: the auxiliary switch is only ever on together with the main one
  assert_aux_needs_main_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl[IDX_AUX] |-> ctl[IDX_MAIN]);

  // R1: the clock is running before isolation drops
  assert_gate_before_iso_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl[IDX_ISO]) |-> !ctl[IDX_GATE]);

  // R8: the clock is only gated once the domain is isolated
  assert_iso_before_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl[IDX_GATE]) |-> ctl[IDX_ISO]);

  // R4: a restore pulse only happens under a gated retention clock
  assert_restore_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl[IDX_REST] |-> (ctl[IDX_RCLK] || ctl[IDX_SCLK]));

  // R7: a save pulse only happens under a gated retention clock
  assert_save_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl[IDX_SAVE] |-> (ctl[IDX_RCLK] || ctl[IDX_SCLK]));

endmodule

// File: rtl/pwrseq_top.sv
`timescale 1ns/1ps
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int ACK_LIMIT   = 1000,
  parameter int HS_LIMIT    = 1000,
  parameter int PHY_ON_GAP  = 250,
  parameter int PHY_OFF_GAP = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       onReq,
  input  logic       offReq,
  input  logic [1:0] retKind,
  input  logic       modemMode,
  input  logic       skipRst,
  input  logic       staMain,
  input  logic       staAux,
  input  logic       memDone,
  input  logic       memFail,
  input  logic       fabDone,
  input  logic       fabFail,
  output logic       swMain,
  output logic       swAux,
  output logic       clkGate,
  output logic       isoEn,
  output logic       domRstN,
  output logic       retClkOff,
  output logic       retSave,
  output logic       retRestoreN,
  output logic       storClkOff,
  output logic       savedFlag,
  output logic       memStart,
  output logic       fabStart,
  output logic       opUp,
  output logic       busy,
  output logic       done,
  output logic       fault
);

  strobe_t            strb;
  logic [NUM_CTL-1:0] ctl;
  retKind_e           kind;

  assign kind = retKind_e'(retKind);

  pwrseq_ctrl #(
    .ACK_LIMIT  (ACK_LIMIT),
    .HS_LIMIT   (HS_LIMIT),
    .PHY_ON_GAP (PHY_ON_GAP),
    .PHY_OFF_GAP(PHY_OFF_GAP)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .onReq    (onReq),
    .offReq   (offReq),
    .kind     (kind),
    .modemMode(modemMode),
    .skipRst  (skipRst),
    .staMain  (staMain),
    .staAux   (staAux),
    .savedFlag(ctl[IDX_FLAG]),
    .memDone  (memDone),
    .memFail  (memFail),
    .fabDone  (fabDone),
    .fabFail  (fabFail),
    .strb     (strb),
    .busy     (busy),
    .done     (done),
    .fault    (fault),
    .opUp     (opUp)
  );

  pwrseq_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .kind    (kind),
    .ctl     (ctl),
    .memStart(memStart),
    .fabStart(fabStart)
  );

  assign swMain      = ctl[IDX_MAIN];
  assign swAux       = ctl[IDX_AUX];
  assign clkGate     = ctl[IDX_GATE];
  assign isoEn       = ctl[IDX_ISO];
  assign domRstN     = ctl[IDX_RST];
  assign retClkOff   = ctl[IDX_RCLK];
  assign retSave     = ctl[IDX_SAVE];
  assign retRestoreN = ctl[IDX_REST];
  assign storClkOff  = ctl[IDX_SCLK];
  assign savedFlag   = ctl[IDX_FLAG];

endmodule

// File: tb/pwrseq_top_tb.sv
`timescale 1ns/1ps
module pwrseq_top_tb;

  localparam int ACK_LIMIT   = 40;
  localparam int HS_LIMIT    = 40;
  localparam int PHY_ON_GAP  = 20;
  localparam int PHY_OFF_GAP = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onReq = 1'b0, offReq = 1'b0;
  logic [1:0] retKind = 2'd0;
  logic modemMode = 1'b0, skipRst = 1'b0;
  logic staMain, staAux;
  logic memDone = 1'b0, memFail = 1'b0, fabDone = 1'b0, fabFail = 1'b0;
  logic swMain, swAux, clkGate, isoEn, domRstN, retClkOff, retSave;
  logic retRestoreN, storClkOff, savedFlag, memStart, fabStart;
  logic opUp, busy, done, fault;

  always #10 clk = ~clk;   // 50 MHz

  pwrseq_top #(
    .ACK_LIMIT(ACK_LIMIT), .HS_LIMIT(HS_LIMIT),
    .PHY_ON_GAP(PHY_ON_GAP), .PHY_OFF_GAP(PHY_OFF_GAP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .onReq(onReq), .offReq(offReq),
    .retKind(retKind), .modemMode(modemMode), .skipRst(skipRst),
    .staMain(staMain), .staAux(staAux),
    .memDone(memDone), .memFail(memFail), .fabDone(fabDone), .fabFail(fabFail),
    .swMain(swMain), .swAux(swAux), .clkGate(clkGate), .isoEn(isoEn),
    .domRstN(domRstN), .retClkOff(retClkOff), .retSave(retSave),
    .retRestoreN(retRestoreN), .storClkOff(storClkOff), .savedFlag(savedFlag),
    .memStart(memStart), .fabStart(fabStart),
    .opUp(opUp), .busy(busy), .done(done), .fault(fault)
  );

  // ---------------- power switch model
  logic [2:0] mainPipe = '0, auxPipe = '0;
  logic stuckAux = 1'b0;
  always @(posedge clk) begin
    mainPipe <= {mainPipe[1:0], swMain};
    auxPipe  <= {auxPipe[1:0], modemMode ? swMain : swAux};
  end
  assign staMain = mainPipe[2];
  assign staAux  = auxPipe[2] & !stuckAux;

  // ---------------- companion models
  logic injMemFail = 1'b0, injFabFail = 1'b0;
  int memCnt = 0, fabCnt = 0;
  always @(posedge clk) begin
    memDone <= 1'b0; memFail <= 1'b0; fabDone <= 1'b0; fabFail <= 1'b0;
    if (memStart) memCnt <= 3;
    else if (memCnt != 0) begin
      memCnt <= memCnt - 1;
      if (memCnt == 1) begin
        if (injMemFail) memFail <= 1'b1; else memDone <= 1'b1;
      end
    end
    if (fabStart) fabCnt <= 3;
    else if (fabCnt != 0) begin
      fabCnt <= fabCnt - 1;
      if (fabCnt == 1) begin
        if (injFabFail) fabFail <= 1'b1; else fabDone <= 1'b1;
      end
    end
  end

  // ---------------- event log (bit*2 + new value; start lines log rises only)
  logic [11:0] obs, prevObs;
  assign obs = {fabStart, memStart, savedFlag, storClkOff, retRestoreN, retSave,
                retClkOff, domRstN, isoEn, clkGate, swAux, swMain};
  int logC [64];
  int logT [64];
  int logN = 0;
  int cyc = 0;
  initial prevObs = 12'b0000_1000_1100;
  always @(negedge clk) begin
    cyc++;
    for (int b = 0; b < 12; b++) begin
      if (obs[b] !== prevObs[b] && (b < 10 || obs[b]) && logN < 64) begin
        logC[logN] = b * 2 + int'(obs[b]);
        logT[logN] = cyc;
        logN++;
      end
    end
    prevObs = obs;
  end

  // ---------------- expected model
  logic [9:0] mdl;
  int expC [64];
  int expN = 0;
  int total = 0, bad = 0;

  task automatic ex(input int b, input bit v);
    if (mdl[b] != v) begin
      expC[expN] = b * 2 + int'(v);
      expN++;
      mdl[b] = v;
    end
  endtask

  task automatic exStart(input int b);
    expC[expN] = b * 2 + 1;
    expN++;
  endtask

  task automatic buildOn(input int k, input bit m, input bit s, input bit stopMem,
                         output bit rest);
    expN = 0;
    rest = 1'b0;
    if (m) begin
      if (!s) ex(4, 1'b1);
      ex(0, 1'b1);
    end else begin
      ex(0, 1'b1); ex(1, 1'b1);
      if (k == 2) ex(5, 1'b1);
      ex(2, 1'b0); ex(3, 1'b0); ex(4, 1'b1);
      rest = (k == 3) || ((k == 1 || k == 2) && mdl[9]);
      if (rest) begin
        if (k != 3) ex(9, 1'b0);
        if (k == 1) ex(5, 1'b1);
        if (k == 3) ex(8, 1'b1);
        ex(7, 1'b0); ex(7, 1'b1);
        if (k == 3) ex(8, 1'b0); else ex(5, 1'b0);
      end
    end
    exStart(10);
    if (!stopMem) exStart(11);
  endtask

  task automatic buildOff(input int k, input bit m, input bit s);
    expN = 0;
    exStart(11); exStart(10);
    if (m) begin
      ex(0, 1'b0);
      if (!s) ex(4, 1'b0);
    end else begin
      if (k != 0) begin
        int c;
        c = (k == 3) ? 8 : 5;
        ex(c, 1'b1); ex(6, 1'b1); ex(6, 1'b0); ex(c, 1'b0);
        if (k != 3) ex(9, 1'b1);
      end
      ex(3, 1'b1); ex(2, 1'b1); ex(4, 1'b0); ex(1, 1'b0); ex(0, 1'b0);
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic checkSeq(input string req);
    int mis;
    mis = -1;
    for (int i = 0; i < expN; i++)
      if (mis < 0 && (i >= logN || logC[i] != expC[i])) mis = i;
    if (mis < 0 && logN != expN) mis = expN;
    if (mis < 0) check(1'b1, req, "event order", 0, 0);
    else check(1'b0, req, $sformatf("event %0d of %0d logged/%0d expected", mis, logN, expN),
               (mis < logN) ? logC[mis] : -1, (mis < expN) ? expC[mis] : -1);
  endtask

  function automatic int findT(input int code);
    for (int i = 0; i < logN; i++) if (logC[i] == code) return logT[i];
    return -1;
  endfunction

  task automatic resetDut();
    rstN = 1'b0;
    injMemFail = 1'b0; injFabFail = 1'b0; stuckAux = 1'b0;
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    mdl = 10'b00_1000_1100;
    @(negedge clk);
  endtask

  // request, stray opposite request while busy, wait for done
  task automatic runOp(input bit up, output bit f, output int len, output bit upSeen);
    @(negedge clk);
    logN = 0;
    onReq = up; offReq = !up;
    @(negedge clk);
    onReq = 1'b0; offReq = 1'b0;
    len = 1;
    repeat (3) begin @(negedge clk); len++; end
    onReq = !up; offReq = up;          // ignored while busy (R13)
    @(negedge clk); len++;
    onReq = 1'b0; offReq = 1'b0;
    upSeen = opUp;
    while (!done && len < 3000) begin @(negedge clk); len++; end
    f = fault;
    check(done, "R10", "done seen", int'(done), 1);
    @(negedge clk);
  endtask

  task automatic quiet();
    int n0;
    n0 = logN;
    repeat (6) @(negedge clk);
    check(logN == n0 && !busy, "R13", "outputs quiet after done", logN - n0, 0);
  endtask

  task automatic finishUp();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    bit f, upS, rest;
    int len;
    resetDut();
    // R12 reset state
    check(obs == 12'b0000_1000_1100, "R12", "reset outputs", int'(obs), 12'h08C);
    check(!busy && !done, "R12", "idle after reset", int'(busy), 0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 4; k++) begin
          if (m == 0 && s == 1) continue;
          if (m == 1 && k != 1) continue;
          modemMode = m[0]; skipRst = s[0]; retKind = k[1:0];
          resetDut();
          for (int pass = 0; pass < 2; pass++) begin
            string tg;
            buildOn(k, m[0], s[0], 1'b0, rest);
            runOp(1'b1, f, len, upS);
            if (m == 1) tg = "R9";
            else if (k == 0) tg = "R1";
            else if (!rest) tg = "R6";
            else tg = (k == 1) ? "R4" : "R5";
            checkSeq(tg);
            check(!f, "R10", "on without fault", int'(f), 0);
            check(upS, "R10", "opUp during on", int'(upS), 1);
            if (m == 0) begin
              int gap;
              gap = findT(9) - findT(6);
              if (k == 2) check(gap >= PHY_ON_GAP, "R3", "iso->reset gap PHY", gap, PHY_ON_GAP);
              else        check(gap >= 1 && gap < PHY_ON_GAP, "R3", "iso->reset gap", gap, 1);
              if (k == 2) check(findT(11) >= 0 && findT(11) < findT(4), "R3",
                                "rclk before clock", findT(11), findT(4));
            end
            quiet();
            buildOff(k, m[0], s[0]);
            runOp(1'b0, f, len, upS);
            checkSeq((m == 1) ? "R9" : (k == 0) ? "R8" : "R7");
            check(!f, "R10", "off without fault", int'(f), 0);
            check(!upS, "R10", "opUp during off", int'(upS), 0);
            if (m == 0) begin
              int gap;
              gap = findT(5) - findT(7);
              if (k == 2) check(gap >= PHY_OFF_GAP, "R8", "iso->gate gap PHY", gap, PHY_OFF_GAP);
              else        check(gap == 1, "R8", "iso->gate gap", gap, 1);
            end
            quiet();
          end
        end
      end
    end

    // R2: one status stuck low -> timeout fault after switches only
    modemMode = 1'b0; skipRst = 1'b0; retKind = 2'd1;
    resetDut();
    stuckAux = 1'b1;
    expN = 0; ex(0, 1'b1); ex(1, 1'b1);
    runOp(1'b1, f, len, upS);
    checkSeq("R2");
    check(f, "R2", "fault on stuck status", int'(f), 1);
    check(len >= ACK_LIMIT, "R2", "timeout length", len, ACK_LIMIT);

    // R11: memory companion fails during power-on
    resetDut();
    injMemFail = 1'b1;
    buildOn(1, 1'b0, 1'b0, 1'b1, rest);
    runOp(1'b1, f, len, upS);
    checkSeq("R11");
    check(f, "R11", "fault on memory fail", int'(f), 1);

    // R11: fabric companion fails during power-off
    resetDut();
    buildOn(1, 1'b0, 1'b0, 1'b0, rest);
    runOp(1'b1, f, len, upS);
    injFabFail = 1'b1;
    expN = 0; exStart(11);
    runOp(1'b0, f, len, upS);
    checkSeq("R11");
    check(f, "R11", "fault on fabric fail", int'(f), 1);
    check(swMain && swAux && isoEn == 1'b0, "R11", "domain left powered",
          int'({swMain, swAux, isoEn}), 6);

    finishUp();
  end

endmodule